// File: doc/BRIEF.md
# Prioritised Multiprocessor Interrupt Controller

The block collects fifteen interrupt request lines (numbered 1 to 15) and hands each of a parameterised number of processors a 4-bit interrupt level. A rising edge on a request line is latched either into one shared pending vector or, when that line is set to broadcast, into the private force vector of every processor. Each processor sees its own masked view of pending and force, split into a high-priority and a low-priority group by a programmable level-select vector. It is presented with the highest-numbered interrupt of the high group, or of the low group when the high group is empty.

Software reaches the state through a 32-bit word-wide register port with a combinational read path. A processor retires an interrupt by pulsing its acknowledge strobe with the interrupt number. That clears the bit in the shared pending vector and in that processor's force vector.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads zero and every processor's level output is 0.
- R2: A rising edge on request line k (1..15) sets bit k of the pending register (offset 0x04) when broadcast bit k is 0, or bit k of every processor's force register when it is 1. Line 0 is ignored.
- R3: Bit 0 of every interrupt vector register always reads 0; only bits 15:1 of written data are kept in level select (0x00), broadcast (0x14) and mask n (0x40+4n).
- R4: For processor n the active set is (pending OR force n) AND mask n. Its level is the highest active bit whose level-select bit is 1, else the highest other active bit, else 0. The output appears on the clock edge after the state change.
- R5: A write to the clear register (0x0C) clears the written bits 15:1 in pending and in every force register. Clear and status (0x10) read as zero. Writes to pending are ignored.
- R6: A write to force n (0x80+4n) uses data bits 15:1 as set bits and bits 31:17 as clear bits (clear bit k at data bit 16+k). The new value is (old OR set) AND NOT clear.
- R7: A write to offset 0x08 replaces force 0 with data bits 15:1. A read of 0x08 returns force 0.
- R8: An acknowledge from processor n with number k clears bit k of pending and of force n.
- R9: Extended register n (0xC0+4n) keeps only data bits 3:0 and has no effect on any level output.
- R10: Only address bits 7:0 are decoded. A write whose byte enables are not all set, or whose address bits 1:0 are not zero, changes nothing. Processor slots n >= NUM_CPU read zero.
- R11: When a request edge and a clear (register or acknowledge) hit the same bit in one cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line | input | 16 | Request lines, bit k is line k, bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables, writes need 4'hF |
| bus_addr | input | 32 | Byte address, bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ack_valid | input | NUM_CPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NUM_CPU | Acknowledged interrupt number, nibble n for processor n |
| irq_level | output | 4*NUM_CPU | Registered interrupt level, nibble n for processor n |

## Verification
Level outputs are driven with several input patterns. Two lines pending under a full mask and under a narrow mask show that masking is applied per processor. Moving one lower line into the high group separates the priority split from plain highest-number selection. A broadcast line retired by one processor only shows that force registers are private while pending is shared. Register-side patterns cover set/clear force writes that touch the same bit, the replace-style alias, writes with partial byte enables or a misaligned address, an address above 255, and a request edge landing in the same cycle as a clear of that bit.

// File: rtl/irqc_pkg.sv
// Package: shared widths, register offsets and decode regions of the
// interrupt controller. Assumes 16-bit interrupt vectors with bit 0 unused.
package irqc_pkg;
    localparam int IRQ_W   = 16;
    localparam int LVL_W   = 4;
    localparam int EXT_W   = 4;
    localparam logic [IRQ_W-1:0] VEC_KEEP = 16'hFFFE;

    localparam logic [7:0] OFF_LVLSEL = 8'h00;
    localparam logic [7:0] OFF_PEND   = 8'h04;
    localparam logic [7:0] OFF_ALIAS  = 8'h08;
    localparam logic [7:0] OFF_CLEAR  = 8'h0C;
    localparam logic [7:0] OFF_STATUS = 8'h10;
    localparam logic [7:0] OFF_BCAST  = 8'h14;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    typedef enum logic [3:0] {
        RG_LVLSEL, RG_PEND, RG_ALIAS, RG_CLEAR, RG_STATUS, RG_BCAST,
        RG_MASK, RG_FORCE, RG_EXT, RG_NONE
    } region_t;
endpackage

// File: rtl/irqc_req_route.sv
// Request router: detects rising edges on the request lines and steers each
// to the shared pending vector or to the broadcast (all-force) vector.
// Assumes request lines are synchronous to clk.
module irqc_req_route
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t irq_line,
    input  irq_vec_t bcast_q,
    output irq_vec_t pend_set,
    output irq_vec_t bcast_set
);
    irq_vec_t line_prev;
    irq_vec_t rise;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= '0;
        else        line_prev <= irq_line;
    end

    // Split new edges between pending and broadcast destinations.
    always_comb begin
        rise      = irq_line & ~line_prev & VEC_KEEP;
        pend_set  = rise & ~bcast_q;
        bcast_set = rise & bcast_q;
    end
endmodule

// File: rtl/irqc_bus_dec.sv
// Bus decoder: maps a byte address (modulo 256) to a register region and a
// processor slot, and qualifies full-word writes. Assumes word accesses.
module irqc_bus_dec
    import irqc_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_addr,
    output region_t     region,
    output logic [3:0]  slot,
    output logic        slot_ok,
    output logic        wr_ok
);
    logic [7:0] offs;

    // Classify the low address byte into a region.
    always_comb begin
        offs = bus_addr[7:0];
        slot = offs[5:2];
        slot_ok = (int'(slot) < NUM_CPU);
        unique case (offs[7:6])
            2'b01:   region = RG_MASK;
            2'b10:   region = RG_FORCE;
            2'b11:   region = RG_EXT;
            default: begin
                case (offs)
                    OFF_LVLSEL: region = RG_LVLSEL;
                    OFF_PEND:   region = RG_PEND;
                    OFF_ALIAS:  region = RG_ALIAS;
                    OFF_CLEAR:  region = RG_CLEAR;
                    OFF_STATUS: region = RG_STATUS;
                    OFF_BCAST:  region = RG_BCAST;
                    default:    region = RG_NONE;
                endcase
            end
        endcase
    end

    // Accept a write only as an aligned full word.
    always_comb begin
        wr_ok = bus_sel && bus_wr && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/irqc_level_enc.sv
// Level encoder for one processor: forms the active set, chooses the high
// or low group and registers the highest-numbered interrupt in it.
// Assumes inputs are registered state; output lags state by one edge.
module irqc_level_enc
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  irq_vec_t         pend_q,
    input  irq_vec_t         force_q,
    input  irq_vec_t         mask_q,
    input  irq_vec_t         lvlsel_q,
    output logic [LVL_W-1:0] level_q
);
    irq_vec_t         active;
    irq_vec_t         chosen;
    logic [LVL_W-1:0] top_idx;

    // Pick the group and find its highest set bit.
    always_comb begin
        active = (pend_q | force_q) & mask_q & VEC_KEEP;
        chosen = ((active & lvlsel_q) != '0) ? (active & lvlsel_q) : (active & ~lvlsel_q);
        top_idx = '0;
        for (int b = 1; b < IRQ_W; b++) begin
            if (chosen[b]) top_idx = LVL_W'(b);
        end
    end

    // Register the level presented to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= top_idx;
    end

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (level_q == '0));
    a_r4_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (active != '0) |=> (level_q != '0));
endmodule

// File: rtl/mp_irq_ctrl.sv
// Multiprocessor interrupt controller top: holds pending, level select,
// broadcast, and per-processor mask/force/extended registers, applies bus
// writes and acknowledges, and drives one registered level per processor.
// Assumes NUM_CPU <= 16; request edges win over same-cycle clears.
module mp_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            irq_line,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_CPU-1:0]     ack_valid,
    input  logic [4*NUM_CPU-1:0]   ack_num,
    output logic [4*NUM_CPU-1:0]   irq_level
);
    irq_vec_t   pend_q, lvlsel_q, bcast_q;
    irq_vec_t   force_q [NUM_CPU];
    irq_vec_t   mask_q  [NUM_CPU];
    logic [EXT_W-1:0] ext_q [NUM_CPU];

    irq_vec_t   pend_set, bcast_set;
    irq_vec_t   ack_clr [NUM_CPU];
    irq_vec_t   ack_any, bus_clr, wlow, wset, wclr;
    region_t    region;
    logic [3:0] slot;
    logic       slot_ok, wr_ok;

    irqc_req_route u_route (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .bcast_q(bcast_q),
        .pend_set(pend_set), .bcast_set(bcast_set)
    );

    irqc_bus_dec #(.NUM_CPU(NUM_CPU)) u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be), .bus_addr(bus_addr),
        .region(region), .slot(slot), .slot_ok(slot_ok), .wr_ok(wr_ok)
    );

    // Derive clear vectors from acknowledges and the clear register.
    always_comb begin
        ack_any = '0;
        for (int n = 0; n < NUM_CPU; n++) begin
            ack_clr[n] = ack_valid[n] ? ((irq_vec_t'(1) << ack_num[4*n +: 4]) & VEC_KEEP) : '0;
            ack_any    = ack_any | ack_clr[n];
        end
        wlow    = bus_wdata[15:0] & VEC_KEEP;
        wset    = wlow;
        wclr    = bus_wdata[31:16] & VEC_KEEP;
        bus_clr = (wr_ok && region == RG_CLEAR) ? wlow : '0;
    end

    // Shared registers: pending, level select and broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            lvlsel_q <= '0;
            bcast_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~(bus_clr | ack_any)) | pend_set;
            if (wr_ok && region == RG_LVLSEL) lvlsel_q <= wlow;
            if (wr_ok && region == RG_BCAST)  bcast_q  <= wlow;
        end
    end

    generate
        for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
            logic     hit;
            irq_vec_t force_base;

            // Resolve the software view of force n before clears and sets.
            always_comb begin
                hit        = wr_ok && slot_ok && (int'(slot) == n);
                force_base = force_q[n];
                if (n == 0 && wr_ok && region == RG_ALIAS) force_base = wlow;
                if (hit && region == RG_FORCE) force_base = (force_base | wset) & ~wclr;
            end

            // Per-processor mask, force and extended registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    force_q[n] <= '0;
                    mask_q[n]  <= '0;
                    ext_q[n]   <= '0;
                end else begin
                    force_q[n] <= (force_base & ~(bus_clr | ack_clr[n])) | bcast_set;
                    if (hit && region == RG_MASK) mask_q[n] <= wlow;
                    if (hit && region == RG_EXT)  ext_q[n]  <= bus_wdata[EXT_W-1:0];
                end
            end

            irqc_level_enc u_enc (
                .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .force_q(force_q[n]),
                .mask_q(mask_q[n]), .lvlsel_q(lvlsel_q), .level_q(irq_level[4*n +: 4])
            );

            a_r8_ack_clears_force: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid[n] && ack_num[4*n +: 4] != 4'd0 && bcast_set == '0 && !wr_ok)
                |=> (force_q[n][$past(ack_num[4*n +: 4])] == 1'b0));
        end
    endgenerate

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (region)
            RG_LVLSEL: bus_rdata = {16'h0, lvlsel_q};
            RG_PEND:   bus_rdata = {16'h0, pend_q};
            RG_ALIAS:  bus_rdata = {16'h0, force_q[0]};
            RG_BCAST:  bus_rdata = {16'h0, bcast_q};
            default:   bus_rdata = '0;
        endcase
        for (int n = 0; n < NUM_CPU; n++) begin
            if (slot_ok && int'(slot) == n) begin
                if (region == RG_MASK)  bus_rdata = {16'h0, mask_q[n]};
                if (region == RG_FORCE) bus_rdata = {16'h0, force_q[n]};
                if (region == RG_EXT)   bus_rdata = {28'h0, ext_q[n]};
            end
        end
    end

    a_r3_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[0] == 1'b0) && (force_q[0][0] == 1'b0) && (lvlsel_q[0] == 1'b0));
    a_r5_pend_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && region == RG_PEND && pend_set == '0 && ack_any == '0) |=> $stable(pend_q));
    a_r5_clear_status_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (region == RG_CLEAR || region == RG_STATUS)) |-> (bus_rdata == 32'h0));
    a_r8_ack_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid[0] && ack_num[3:0] != 4'd0 && pend_set == '0)
        |=> (pend_q[$past(ack_num[3:0])] == 1'b0));
endmodule

// File: tb/mp_irq_ctrl_test.sv
module mp_irq_ctrl_test;
    localparam int NC = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       irq_line = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_be = 4'hF;
    logic [31:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     ack_valid = '0;
    logic [4*NC-1:0]   ack_num = '0;
    logic [4*NC-1:0]   irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_pend, m_lvl, m_bc, m_prev;
    int m_force [NC];
    int m_mask  [NC];
    int m_ext   [NC];
    logic [4*NC-1:0] exp_level = '0;

    mp_irq_ctrl #(.NUM_CPU(NC)) uut (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_num(ack_num), .irq_level(irq_level)
    );

    always #4 clk = ~clk;

    function automatic int pick_level(int act, int sel);
        int grp;
        int r;
        grp = ((act & sel) != 0) ? (act & sel) : (act & ~sel);
        r = 0;
        for (int b = 15; b >= 1; b--) if (r == 0 && ((grp >> b) & 1) != 0) r = b;
        return r;
    endfunction

    // Reference model step on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_lvl = 0; m_bc = 0; m_prev = 0; exp_level = '0;
            for (int n = 0; n < NC; n++) begin m_force[n] = 0; m_mask[n] = 0; m_ext[n] = 0; end
        end else begin
            int rise, bclr, anyack, a, wd, wlo;
            bit wok;
            int ackb [NC];
            for (int n = 0; n < NC; n++)
                exp_level[4*n +: 4] = 4'(pick_level((m_pend | m_force[n]) & m_mask[n], m_lvl));
            rise = int'(irq_line) & ~m_prev & 'hFFFE;
            m_prev = int'(irq_line);
            wok = bus_sel && bus_wr && bus_be == 4'hF && bus_addr[1:0] == 2'b00;
            a = int'(bus_addr[7:0]);
            wd = int'(bus_wdata);
            wlo = wd & 'hFFFE;
            bclr = (wok && a == 'h0C) ? wlo : 0;
            anyack = 0;
            for (int n = 0; n < NC; n++) begin
                ackb[n] = ack_valid[n] ? ((1 << ack_num[4*n +: 4]) & 'hFFFE) : 0;
                anyack |= ackb[n];
            end
            for (int n = 0; n < NC; n++) begin
                int f;
                f = m_force[n];
                if (n == 0 && wok && a == 'h08) f = wlo;
                if (wok && a == 'h80 + 4*n) f = (f | wlo) & ~((wd >>> 16) & 'hFFFE);
                m_force[n] = (f & ~(bclr | ackb[n])) | (rise & m_bc);
                if (wok && a == 'h40 + 4*n) m_mask[n] = wlo;
                if (wok && a == 'hC0 + 4*n) m_ext[n] = wd & 'hF;
            end
            m_pend = (m_pend & ~(bclr | anyack)) | (rise & ~m_bc);
            if (wok && a == 'h00) m_lvl = wlo;
            if (wok && a == 'h14) m_bc = wlo;
        end
    end

    // R4: compare every processor level to the model on every cycle.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (irq_level !== exp_level) begin
                errors++;
                $display("FAIL R4 level actual %h expected %h at %0t", irq_level, exp_level, $time);
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be = 4'hF, input logic [15:0] ln = 16'h0);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be; irq_line = ln;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 4'hF; irq_line = '0;
    endtask

    task automatic pulse(input logic [15:0] ln);
        @(negedge clk); irq_line = ln;
        @(negedge clk); irq_line = '0;
    endtask

    task automatic ack(input int cpu, input logic [3:0] num);
        @(negedge clk); ack_valid[cpu] = 1; ack_num[4*cpu +: 4] = num;
        @(negedge clk); ack_valid = '0; ack_num = '0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h actual %h expected %h", req, a, bus_rdata, exp);
        end
        bus_sel = 0;
    endtask

    task automatic lvl(input int cpu, input logic [3:0] exp, input string req);
        @(negedge clk); @(negedge clk);
        #1;
        checks++;
        if (irq_level[4*cpu +: 4] !== exp) begin
            errors++;
            $display("FAIL %s cpu%0d level actual %0d expected %0d", req, cpu, irq_level[4*cpu +: 4], exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(32'h00, 0, "R1"); rd(32'h04, 0, "R1"); rd(32'h14, 0, "R1");
        rd(32'h40, 0, "R1"); rd(32'h84, 0, "R1"); lvl(0, 0, "R1");
        // R3 masks keep bits 15:1
        wr(32'h40, 32'hFFFF_FFFF); rd(32'h40, 32'hFFFE, "R3");
        wr(32'h44, 32'h0000_00F0); rd(32'h44, 32'h00F0, "R3");
        // R2 pending from edges; line 0 ignored
        pulse(16'h0089); rd(32'h04, 32'h0088, "R2");
        lvl(0, 7, "R4"); lvl(1, 7, "R4");
        // R4 high group beats a higher-numbered low interrupt
        wr(32'h00, 32'h0000_0009); rd(32'h00, 32'h0008, "R3");
        lvl(0, 3, "R4"); lvl(1, 7, "R4");
        // R8 acknowledge clears pending
        ack(0, 4'd3); rd(32'h04, 32'h0080, "R8"); lvl(0, 7, "R8");
        // R2 broadcast steering
        wr(32'h14, 32'h0000_0021); rd(32'h14, 32'h0020, "R3");
        pulse(16'h0020);
        rd(32'h80, 32'h0020, "R2"); rd(32'h84, 32'h0020, "R2"); rd(32'h04, 32'h0080, "R2");
        // R8 ack only clears the acknowledging processor's force
        ack(1, 4'd5); rd(32'h84, 0, "R8"); rd(32'h80, 32'h0020, "R8");
        // R6 set/clear write
        wr(32'h84, 32'h0004_0006); rd(32'h84, 32'h0002, "R6");
        // R7 alias replaces force 0
        wr(32'h08, 32'h0000_1001); rd(32'h08, 32'h1000, "R7"); rd(32'h80, 32'h1000, "R7");
        lvl(0, 12, "R7");
        // R5 clear register and read-as-zero registers
        wr(32'h0C, 32'h0000_FFFF);
        rd(32'h04, 0, "R5"); rd(32'h80, 0, "R5"); rd(32'h84, 0, "R5");
        rd(32'h0C, 0, "R5"); rd(32'h10, 0, "R5"); lvl(0, 0, "R5");
        pulse(16'h0200); wr(32'h04, 32'h0000_FFFF); rd(32'h04, 32'h0200, "R5");
        // R9 extended register
        wr(32'hC0, 32'h0000_00FF); rd(32'hC0, 32'h000F, "R9"); lvl(0, 9, "R9");
        // R10 partial, misaligned, aliased and out-of-range accesses
        wr(32'h40, 32'h0, 4'h3); rd(32'h40, 32'hFFFE, "R10");
        wr(32'h41, 32'h0); rd(32'h40, 32'hFFFE, "R10");
        wr(32'h0000_0144, 32'h0000_0300); rd(32'h44, 32'h0300, "R10"); lvl(1, 9, "R10");
        rd(32'h48, 0, "R10"); rd(32'h88, 0, "R10");
        // R11 edge wins over same-cycle clear
        wr(32'h0C, 32'h0000_0400, 4'hF, 16'h0400); rd(32'h04, 32'h0600, "R11");
        lvl(0, 10, "R11");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule